// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is a watchdog timer behind a small 32-bit register port. Software programs a clock divisor and a 16-bit reload count, sets a run bit, and must then keep the timer alive before the count runs out. If it fails to, the block raises a one-cycle timeout pulse and a sticky expired flag. The system reset logic is expected to act on that pulse.

Every write has to carry the key 0x1234 in its upper sixteen bits. Without the key the write changes nothing and sets a sticky key-error flag. Only the lower sixteen bits of a keyed write carry data.

The keep-alive register holds three independent two-bit groups. Each group acts only when software flips it between the values 1 and 2:

- The configuration group moves the programmed divisor and reload count into the working copy that the counter uses.
- The counter group reloads the down-counter.
- The interrupt group clears the expired flag.

Top module: `keyed_wdt`

## Requirements
- R1: A write (req_valid and req_write high) is accepted only when req_wdata[31:16] equals 0x1234. A write with any other key changes no register and sets the key-error flag, which reads as bit 0 at offset 0x00. The flag stays set until a keyed write to offset 0x00 with bit 0 set.
- R2: After reset the registers read as follows: 0x0F00 at offset 0x04 (divisor 16), 0xFFFF at offset 0x08, 0x0000 at offset 0x1C, 0x0015 at offset 0x18, 0xFFFF as the current count at offset 0x10, and 0x0000 at offset 0x00.
- R3: rsp_rdata follows req_addr combinationally. Bits 15:0 hold the stored value and bits 31:16 are zero. Unmapped offsets read as zero.
- R4: Offset 0x04 bits 15:8 hold the divisor minus one, which gives divisors 1 to 256. Offset 0x08 holds the reload count. Writes to either register have no effect on counting until a configuration refresh.
- R5: Offset 0x18 holds three groups: bits 5:4 (configuration), bits 3:2 (counter) and bits 1:0 (interrupt). A group acts, and stores its new value, only when the written value is 1 or 2 and differs from the stored value. A written value of 0 or 3, or an unchanged value, leaves the group as it was.
- R6: A configuration refresh copies the programmed divisor and reload count into the working copy. A counter refresh loads the count from the working reload value, clears the prescaler and clears the expired flag. When both groups act in one write, the counter loads the newly programmed count.
- R7: Offset 0x1C bit 0 is the run bit. While it is set, the count falls by one every divisor cycles. While it is clear, the count and the prescaler hold.
- R8: On the step of the count from 1 to 0, wdt_timeout is high for exactly one cycle and wdt_expired sets. The count then stays at 0 with no further pulse until it is reloaded.
- R9: An interrupt-group refresh clears wdt_expired. Offset 0x00 bit 1 reads the expired flag.
- R10: With the run bit set, a counter reload (or the setting of the run bit after a reload) at a clock edge is followed by the timeout pulse exactly count × divisor cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request qualifier |
| req_write | input | 1 | High for a write |
| req_addr | input | 5 | Byte offset of the register |
| req_wdata | input | 32 | Key in bits 31:16, data in bits 15:0 |
| rsp_rdata | output | 32 | Read data for req_addr |
| wdt_timeout | output | 1 | One-cycle pulse on expiry |
| wdt_expired | output | 1 | Sticky expired flag |

## Verification
The bench targets the following corner cases:

- **Keyless writes.** A design that checked too few key bits would let a keyless write stop a running timer or change the load value.
- **Refresh values 0 and 3, and unchanged values.** A design that acted on these would reload the counter on garbage writes.
- **Same-write configuration and counter refresh.** A design that ordered these two actions wrongly would load the stale count.
- **Timeout distance at divisors 1, 4 and 256.** A prescaler that was off by one would be caught here.
- **Behaviour at zero.** The bench checks that the counter stays at zero without a second pulse and that the expired flag clears only through the proper refresh groups.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned BUS_W    = 32;
    localparam int unsigned HALF_W   = BUS_W / 2;
    localparam int unsigned NUM_GRP  = 3;
    localparam int unsigned RFSH_W   = 2 * NUM_GRP;
    localparam int unsigned DIV_LSB  = 8;

    // refresh group indices (bit position = 2 * index)
    localparam int unsigned GRP_INT  = 0;
    localparam int unsigned GRP_CNT  = 1;
    localparam int unsigned GRP_CFG  = 2;

    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_LOAD = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_RFSH = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h1C;

    localparam logic [RFSH_W-1:0] RFSH_RST = 6'b01_01_01;
endpackage

// File: rtl/keyed_wdt_regs.sv
module keyed_wdt_regs
    import keyed_wdt_pkg::*;
#(
    parameter logic [HALF_W-1:0] KEY      = 16'h1234,
    parameter int unsigned       CNT_W    = 16,
    parameter int unsigned       DIV_W    = 8,
    parameter int unsigned       RST_DIV  = 16,
    parameter logic [CNT_W-1:0]  RST_LOAD = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic [DIV_W-1:0]  shd_div_m1,
    output logic [CNT_W-1:0]  shd_load,
    output logic              run_en,
    output logic              key_err,
    output logic [RFSH_W-1:0] rfsh_val,
    output logic              fire_cfg,
    output logic              fire_cnt,
    output logic              fire_int
);
    typedef struct packed {
        logic [DIV_W-1:0]  div_m1;
        logic [CNT_W-1:0]  load;
        logic              run;
        logic              kerr;
        logic [RFSH_W-1:0] rfsh;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_req, key_ok, wr_ok, wr_bad;
    logic [NUM_GRP-1:0] grp_fire;

    assign wr_req = req_valid && req_write;
    assign key_ok = (req_wdata[BUS_W-1:HALF_W] == KEY);
    assign wr_ok  = wr_req && key_ok;
    assign wr_bad = wr_req && !key_ok;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [1:0] new_v;
        logic [1:0] old_v;
        assign new_v = req_wdata[2*g +: 2];
        assign old_v = regs_q.rfsh[2*g +: 2];
        assign grp_fire[g] = wr_ok && (req_addr == OFS_RFSH) && (new_v != old_v)
                             && ((new_v == 2'd1) || (new_v == 2'd2));
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_bad) begin
            regs_d.kerr = 1'b1;
        end
        if (wr_ok) begin
            case (req_addr)
                OFS_STAT: if (req_wdata[0]) regs_d.kerr = 1'b0;
                OFS_CFG:  regs_d.div_m1 = req_wdata[DIV_LSB +: DIV_W];
                OFS_LOAD: regs_d.load   = req_wdata[CNT_W-1:0];
                OFS_CTRL: regs_d.run    = req_wdata[0];
                OFS_RFSH: begin
                    for (int g = 0; g < NUM_GRP; g++) begin
                        if (grp_fire[g]) regs_d.rfsh[2*g +: 2] = req_wdata[2*g +: 2];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.div_m1 <= DIV_W'(RST_DIV - 1);
            regs_q.load   <= RST_LOAD;
            regs_q.run    <= 1'b0;
            regs_q.kerr   <= 1'b0;
            regs_q.rfsh   <= RFSH_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign shd_div_m1 = regs_q.div_m1;
    assign shd_load   = regs_q.load;
    assign run_en     = regs_q.run;
    assign key_err    = regs_q.kerr;
    assign rfsh_val   = regs_q.rfsh;
    assign fire_cfg   = grp_fire[GRP_CFG];
    assign fire_cnt   = grp_fire[GRP_CNT];
    assign fire_int   = grp_fire[GRP_INT];
endmodule

// File: rtl/keyed_wdt_core.sv
module keyed_wdt_core #(
    parameter int unsigned      CNT_W    = 16,
    parameter int unsigned      DIV_W    = 8,
    parameter int unsigned      RST_DIV  = 16,
    parameter logic [CNT_W-1:0] RST_LOAD = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] shd_div_m1,
    input  logic [CNT_W-1:0] shd_load,
    input  logic             run_en,
    input  logic             fire_cfg,
    input  logic             fire_cnt,
    input  logic             fire_int,
    output logic [CNT_W-1:0] cnt_val,
    output logic             tmo_pulse,
    output logic             expired
);
    typedef struct packed {
        logic [DIV_W-1:0] adiv;
        logic [CNT_W-1:0] aload;
        logic [DIV_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             tmo;
        logic             exp;
    } core_t;

    core_t core_d, core_q;
    logic [CNT_W-1:0] reload_val;

    assign reload_val = fire_cfg ? shd_load : core_q.aload;

    always_comb begin
        core_d     = core_q;
        core_d.tmo = 1'b0;
        if (fire_int) begin
            core_d.exp = 1'b0;
        end
        if (fire_cfg) begin
            core_d.adiv  = shd_div_m1;
            core_d.aload = shd_load;
        end
        if (fire_cnt) begin
            core_d.cnt = reload_val;
            core_d.pre = '0;
            core_d.exp = 1'b0;
        end else if (run_en) begin
            if (core_q.pre == core_q.adiv) begin
                core_d.pre = '0;
                if (core_q.cnt != '0) begin
                    core_d.cnt = core_q.cnt - CNT_W'(1);
                    if (core_q.cnt == CNT_W'(1)) begin
                        core_d.tmo = 1'b1;
                        core_d.exp = 1'b1;
                    end
                end
            end else begin
                core_d.pre = core_q.pre + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.adiv  <= DIV_W'(RST_DIV - 1);
            core_q.aload <= RST_LOAD;
            core_q.pre   <= '0;
            core_q.cnt   <= RST_LOAD;
            core_q.tmo   <= 1'b0;
            core_q.exp   <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    assign cnt_val   = core_q.cnt;
    assign tmo_pulse = core_q.tmo;
    assign expired   = core_q.exp;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter logic [HALF_W-1:0] KEY      = 16'h1234,
    parameter int unsigned       CNT_W    = 16,
    parameter int unsigned       DIV_W    = 8,
    parameter int unsigned       RST_DIV  = 16,
    parameter logic [CNT_W-1:0]  RST_LOAD = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic [BUS_W-1:0]  rsp_rdata,
    output logic              wdt_timeout,
    output logic              wdt_expired
);
    logic [DIV_W-1:0]  shd_div_m1;
    logic [CNT_W-1:0]  shd_load;
    logic              run_en;
    logic              key_err;
    logic [RFSH_W-1:0] rfsh_val;
    logic              fire_cfg, fire_cnt, fire_int;
    logic [CNT_W-1:0]  cnt_val;

    keyed_wdt_regs #(
        .KEY(KEY), .CNT_W(CNT_W), .DIV_W(DIV_W), .RST_DIV(RST_DIV), .RST_LOAD(RST_LOAD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .shd_div_m1(shd_div_m1),
        .shd_load(shd_load), .run_en(run_en), .key_err(key_err), .rfsh_val(rfsh_val),
        .fire_cfg(fire_cfg), .fire_cnt(fire_cnt), .fire_int(fire_int)
    );

    keyed_wdt_core #(
        .CNT_W(CNT_W), .DIV_W(DIV_W), .RST_DIV(RST_DIV), .RST_LOAD(RST_LOAD)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .shd_div_m1(shd_div_m1), .shd_load(shd_load),
        .run_en(run_en), .fire_cfg(fire_cfg), .fire_cnt(fire_cnt), .fire_int(fire_int),
        .cnt_val(cnt_val), .tmo_pulse(wdt_timeout), .expired(wdt_expired)
    );

    always_comb begin
        rsp_rdata = '0;
        case (req_addr)
            OFS_STAT: rsp_rdata[1:0]              = {wdt_expired, key_err};
            OFS_CFG:  rsp_rdata[DIV_LSB +: DIV_W] = shd_div_m1;
            OFS_LOAD: rsp_rdata[CNT_W-1:0]        = shd_load;
            OFS_CNT:  rsp_rdata[CNT_W-1:0]        = cnt_val;
            OFS_RFSH: rsp_rdata[RFSH_W-1:0]       = rfsh_val;
            OFS_CTRL: rsp_rdata[0]                = run_en;
            default:  rsp_rdata                   = '0;
        endcase
    end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
    import keyed_wdt_pkg::*;
#(
    parameter logic [HALF_W-1:0] KEY   = 16'h1234,
    parameter int unsigned       CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [BUS_W-1:0]  req_wdata,
    input logic [BUS_W-1:0]  rsp_rdata,
    input logic              wdt_timeout,
    input logic              wdt_expired,
    input logic [CNT_W-1:0]  cnt_val,
    input logic              run_en,
    input logic              fire_cnt,
    input logic              key_err
);
    // R1
    bad_key_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_wdata[BUS_W-1:HALF_W] != KEY) |-> !fire_cnt);
    // R1
    bad_key_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_wdata[BUS_W-1:HALF_W] != KEY) |=> key_err);
    // R3
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[BUS_W-1:HALF_W] == '0);
    // R6
    reload_clears_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_cnt |=> !wdt_expired);
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !fire_cnt) |=> $stable(cnt_val));
    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !wdt_timeout);
    // R8
    pulse_sets_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |-> (wdt_expired && cnt_val == '0));
endmodule

bind keyed_wdt keyed_wdt_chk #(.KEY(KEY), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .wdt_timeout(wdt_timeout),
    .wdt_expired(wdt_expired), .cnt_val(cnt_val), .run_en(run_en),
    .fire_cnt(fire_cnt), .key_err(key_err)
);

// File: tb/test_keyed_wdt.sv
`timescale 1ns/1ps
module test_keyed_wdt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = 5'h0;
    logic [31:0] req_wdata = 32'h0;
    logic [31:0] rsp_rdata;
    logic        wdt_timeout, wdt_expired;

    int nvec = 0, nfail = 0, cyc = 0, npulse = 0, t_wr = 0;
    bit finished = 0;

    localparam logic [31:0] K = 32'h1234_0000;

    keyed_wdt i_keyed_wdt (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .wdt_timeout(wdt_timeout), .wdt_expired(wdt_expired)
    );

    always #2 clk = ~clk;

    // behavioural reference model
    int m_div, m_load, m_run, m_kerr, a_div, a_load, m_pre, m_cnt, m_tmo, m_exp;
    int m_rf[3];

    function automatic logic [31:0] mread(input logic [4:0] a);
        case (a)
            5'h00: return 32'(m_exp * 2 + m_kerr);
            5'h04: return 32'(m_div * 256);
            5'h08: return 32'(m_load);
            5'h10: return 32'(m_cnt);
            5'h18: return 32'(m_rf[2] * 16 + m_rf[1] * 4 + m_rf[0]);
            5'h1C: return 32'(m_run);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        int fire[3];
        int nv, n_cnt, n_pre, n_exp, n_tmo;
        bit wr, ok;
        cyc++;
        if (!rst_n) begin
            m_div = 15; m_load = 65535; m_run = 0; m_kerr = 0;
            a_div = 15; a_load = 65535; m_pre = 0; m_cnt = 65535; m_tmo = 0; m_exp = 0;
            for (int g = 0; g < 3; g++) m_rf[g] = 1;
        end else begin
            wr = req_valid && req_write;
            ok = (req_wdata[31:16] == 16'h1234);
            for (int g = 0; g < 3; g++) begin
                nv = int'((req_wdata >> (2 * g)) & 32'd3);
                fire[g] = (wr && ok && req_addr == 5'h18 && nv != m_rf[g] && (nv == 1 || nv == 2)) ? 1 : 0;
            end
            n_cnt = m_cnt; n_pre = m_pre; n_exp = m_exp; n_tmo = 0;
            if (fire[0] != 0) n_exp = 0;
            if (fire[1] != 0) begin
                n_cnt = (fire[2] != 0) ? m_load : a_load;
                n_pre = 0; n_exp = 0;
            end else if (m_run != 0) begin
                if (m_pre == a_div) begin
                    n_pre = 0;
                    if (m_cnt > 0) begin
                        n_cnt = m_cnt - 1;
                        if (m_cnt == 1) begin n_tmo = 1; n_exp = 1; end
                    end
                end else n_pre = m_pre + 1;
            end
            if (fire[2] != 0) begin a_div = m_div; a_load = m_load; end
            m_cnt = n_cnt; m_pre = n_pre; m_exp = n_exp; m_tmo = n_tmo;
            if (wr && !ok) m_kerr = 1;
            if (wr && ok) begin
                case (req_addr)
                    5'h00: if (req_wdata[0]) m_kerr = 0;
                    5'h04: m_div = int'(req_wdata[15:8]);
                    5'h08: m_load = int'(req_wdata[15:0]);
                    5'h1C: m_run = int'(req_wdata[0]);
                    5'h18: for (int g = 0; g < 3; g++)
                               if (fire[g] != 0) m_rf[g] = int'((req_wdata >> (2 * g)) & 32'd3);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            if (wdt_timeout) npulse++;
            chk("R3 per-cycle read", rsp_rdata, mread(req_addr));
            chk("R8 per-cycle timeout", {31'b0, wdt_timeout}, 32'(m_tmo));
            chk("R9 per-cycle expired", {31'b0, wdt_expired}, 32'(m_exp));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1 t_wr = cyc;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        req_addr = a;
        #1 v = rsp_rdata;
    endtask

    task automatic wait_pulse(output int delta);
        delta = -1;
        for (int i = 0; i < 2000; i++) begin
            if (wdt_timeout) begin delta = cyc - t_wr; break; end
            @(posedge clk);
            #1;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        int d, p0;
        idle(3);
        @(negedge clk) rst_n = 1'b1;

        // R2 reset state
        rd(5'h04, v); chk("R2 cfg reset", v, 32'h0F00);
        rd(5'h08, v); chk("R2 load reset", v, 32'hFFFF);
        rd(5'h1C, v); chk("R2 ctrl reset", v, 32'h0);
        rd(5'h18, v); chk("R2 refresh reset", v, 32'h15);
        rd(5'h10, v); chk("R2 count reset", v, 32'hFFFF);
        rd(5'h00, v); chk("R2 status reset", v, 32'h0);
        rd(5'h0C, v); chk("R3 unmapped", v, 32'h0);

        // R1 key check
        wr(5'h08, 32'hABCD_0005);
        rd(5'h08, v); chk("R1 bad key ignored", v, 32'hFFFF);
        rd(5'h00, v); chk("R1 key error set", v, 32'h1);
        wr(5'h00, K | 32'h1);
        rd(5'h00, v); chk("R1 key error cleared", v, 32'h0);

        // R4 staged config
        wr(5'h04, K | 32'h0300);
        wr(5'h08, K | 32'd10);
        rd(5'h04, v); chk("R4 cfg stored", v, 32'h0300);
        rd(5'h10, v); chk("R4 count untouched", v, 32'hFFFF);

        // R5 ignored refresh values
        wr(5'h18, K | 32'h15);
        wr(5'h18, K | 32'h3F);
        wr(5'h18, K | 32'h00);
        rd(5'h18, v); chk("R5 refresh unchanged", v, 32'h15);
        rd(5'h10, v); chk("R5 no reload", v, 32'hFFFF);

        // R6 cfg + cnt in one write
        wr(5'h18, K | 32'h29);
        rd(5'h10, v); chk("R6 reload with new load", v, 32'd10);
        rd(5'h18, v); chk("R5 refresh stored", v, 32'h29);

        // R10 timeout distance, divisor 4
        p0 = npulse;
        wr(5'h1C, K | 32'h1);
        wait_pulse(d); chk("R10 div4 delay", 32'(d), 32'd40);
        idle(25);
        @(negedge clk);
        chk("R8 single pulse", 32'(npulse - p0), 32'd1);
        rd(5'h10, v); chk("R8 count held at zero", v, 32'h0);
        rd(5'h00, v); chk("R9 status expired", v, 32'h2);

        // R9 interrupt refresh clears expired
        wr(5'h18, K | 32'h2A);
        rd(5'h00, v); chk("R9 expired cleared", v, 32'h0);

        // R6 counter refresh, then R7 stop holds
        wr(5'h18, K | 32'h26);
        rd(5'h10, v); chk("R6 counter reloaded", v, 32'd10);
        wr(5'h1C, K | 32'h0);
        rd(5'h10, v);
        idle(30);
        rd(5'h10, v2); chk("R7 count holds when stopped", v2, v);

        // R10 divisor 1 boundary
        wr(5'h04, K | 32'h0000);
        wr(5'h08, K | 32'd3);
        wr(5'h18, K | 32'h1A);
        wr(5'h1C, K | 32'h1);
        wait_pulse(d); chk("R10 div1 delay", 32'(d), 32'd3);

        // R1 keyless stop attempt while running
        wr(5'h1C, 32'h0000_0000);
        rd(5'h1C, v); chk("R1 keyless stop ignored", v, 32'h1);

        // R10 divisor 256 boundary, reload while running
        wr(5'h04, K | 32'hFF00);
        wr(5'h08, K | 32'd2);
        wr(5'h18, K | 32'h26);
        wait_pulse(d); chk("R10 div256 delay", 32'(d), 32'd512);
        rd(5'h04, v); chk("R4 max divisor field", v, 32'hFF00);

        idle(5);
        finish_run();
    end
endmodule